// File: doc/BRIEF.md
# SONET Transmit Frame Timer with Synchronous Halt

This block produces the byte-rate timing skeleton of a 155.52 Mbit/s STS-3c / STM-1 transmit stream. It runs on the 19.44 MHz byte clock (line rate divided by eight). It walks a row/column position through each 125 µs frame of 9 rows by 270 byte columns and marks the first byte of every frame with a one-clock pulse. It also gates an 8-bit data path toward a serializer or parallel PMD port with a valid flag. Overhead and payload logic elsewhere reads the published position and supplies the byte. The block registers that byte, with the position and valid flag, and presents them on the next edge.

A synchronous halt input stops frame output at once. While it is sampled high, the block holds everything at zero. Output does not resume in the middle of a frame. A fresh frame starts on the ninth rising edge after the last edge that saw the halt high. A new high sample during this countdown restarts the count. Reset behaves like a halt: the first frame appears nine edges after the last edge with reset high.

Top module: `sts3c_frame_timer`

## Requirements
- R1: On every edge with `rst` high, all outputs are cleared (`tx_valid_o`=0, `frame_pulse_o`=0, `tx_byte_o`=0, `row_o`=0, `col_o`=0). The first byte appears after the ninth edge counted from the last edge with `rst` high.
- R2: While output runs, `col_o` counts 0 to 269, advancing by one per clock. When `col_o` wraps from 269 to 0, `row_o` advances by one within the range 0 to 8.
- R3: One frame is 2430 clocks long. Position (row 8, col 269) is followed directly by (row 0, col 0), so frame pulses recur every 2430 clocks of continuous output.
- R4: `frame_pulse_o` is high for exactly one clock, only together with `tx_valid_o`=1, `row_o`=0 and `col_o`=0.
- R5: After any edge at which `halt_i` is sampled high, the outputs show `tx_valid_o`=0, `frame_pulse_o`=0, `tx_byte_o`=0, `row_o`=0 and `col_o`=0. This holds even when the halt lands mid-frame or on the frame-wrap edge.
- R6: Counting the last edge that sampled `halt_i` high as edge 0, the outputs remain idle after edges 1 to 8. After edge 9, `tx_valid_o`=1 and `frame_pulse_o`=1, at row 0, col 0.
- R7: A high sample of `halt_i` during the restart countdown, including on edge 9 itself, reloads the countdown. The nine-edge rule then counts from that newest sample.
- R8: While `tx_valid_o` is 1, `tx_byte_o` equals `tx_byte_i` as sampled on the same edge that presented the current position. While `tx_valid_o` is 0, `tx_byte_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 19.44 MHz transmit byte clock |
| rst | input | 1 | Synchronous active-high reset; acts as a halt |
| halt_i | input | 1 | Synchronous stop request, sampled on the rising edge |
| tx_byte_i | input | DW (8) | Byte from overhead/payload logic for the next position |
| tx_byte_o | output | DW (8) | Registered byte toward the PMD side, zero when idle |
| tx_valid_o | output | 1 | High while frame output runs |
| frame_pulse_o | output | 1 | One-clock marker on the first byte of each frame |
| row_o | output | 4 | Row of the byte on `tx_byte_o` (0..8) |
| col_o | output | 9 | Column of the byte on `tx_byte_o` (0..269) |

## Verification
A halt can arrive on the very edge at which the position would wrap from the last byte of a frame to the next frame's first byte. The halt must win: no pulse and no valid byte. The bench provokes this by running a full frame up to row 8, column 269 and raising the halt exactly for the wrap edge. A second collision is a fresh halt sample on the ninth edge of a restart countdown, where the start and the reload compete. That case is judged by confirming idle output on that edge and a restart exactly nine edges later.

// File: rtl/frm_pkg.sv
package frm_pkg;

  localparam int unsigned DEF_DW    = 8;
  localparam int unsigned DEF_ROWS  = 9;
  localparam int unsigned DEF_COLS  = 270;
  localparam int unsigned DEF_HOLD  = 9;

  // Bits needed to hold values 0..n-1 (at least one bit).
  function automatic int unsigned cw(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/frm_restart_ctl.sv
module frm_restart_ctl #(
  parameter int unsigned HOLD_EDGES = frm_pkg::DEF_HOLD
) (
  input  logic clk,
  input  logic rst,
  input  logic halt_i,
  output logic active_nxt,
  output logic running_q
);
  localparam int unsigned      CW     = frm_pkg::cw(HOLD_EDGES);
  localparam logic [CW-1:0]    RELOAD = CW'(HOLD_EDGES - 1);

  logic [CW-1:0] wait_q;
  logic          block;

  assign block      = rst | halt_i;
  // Output for the coming cycle: keeps running, or starts once the wait is spent.
  assign active_nxt = !block && (running_q || (wait_q == '0));

  always_ff @(posedge clk) begin
    if (block) begin
      wait_q    <= RELOAD;
      running_q <= 1'b0;
    end else begin
      if (wait_q != '0) wait_q <= wait_q - 1'b1;
      running_q <= active_nxt;
    end
  end
endmodule

// File: rtl/frm_pos_ctr.sv
module frm_pos_ctr #(
  parameter int unsigned ROWS = frm_pkg::DEF_ROWS,
  parameter int unsigned COLS = frm_pkg::DEF_COLS
) (
  input  logic                           clk,
  input  logic                           active_nxt,
  input  logic                           running_q,
  output logic [frm_pkg::cw(ROWS)-1:0]   row_q,
  output logic [frm_pkg::cw(COLS)-1:0]   col_q,
  output logic                           origin_nxt
);
  localparam int unsigned RW = frm_pkg::cw(ROWS);
  localparam int unsigned CW = frm_pkg::cw(COLS);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

  logic [RW-1:0] row_n;
  logic [CW-1:0] col_n;

  always_comb begin
    row_n = '0;
    col_n = '0;
    if (active_nxt && running_q) begin
      if (col_q == COL_LAST) begin
        col_n = '0;
        row_n = (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
      end else begin
        col_n = col_q + 1'b1;
        row_n = row_q;
      end
    end
  end

  assign origin_nxt = (row_n == '0) && (col_n == '0);

  always_ff @(posedge clk) begin
    row_q <= row_n;
    col_q <= col_n;
  end
endmodule

// File: rtl/frm_out_stage.sv
module frm_out_stage #(
  parameter int unsigned DW = frm_pkg::DEF_DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active_nxt,
  input  logic          origin_nxt,
  input  logic [DW-1:0] byte_i,
  output logic [DW-1:0] byte_q,
  output logic          pulse_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      byte_q  <= active_nxt ? byte_i : '0;
      pulse_q <= active_nxt && origin_nxt;
    end
  end
endmodule

// File: rtl/sts3c_frame_timer.sv
module sts3c_frame_timer #(
  parameter int unsigned DW         = frm_pkg::DEF_DW,
  parameter int unsigned ROWS       = frm_pkg::DEF_ROWS,
  parameter int unsigned COLS       = frm_pkg::DEF_COLS,
  parameter int unsigned HOLD_EDGES = frm_pkg::DEF_HOLD
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         halt_i,
  input  logic [DW-1:0]                tx_byte_i,
  output logic [DW-1:0]                tx_byte_o,
  output logic                         tx_valid_o,
  output logic                         frame_pulse_o,
  output logic [frm_pkg::cw(ROWS)-1:0] row_o,
  output logic [frm_pkg::cw(COLS)-1:0] col_o
);
  logic active_nxt;
  logic running_q;
  logic origin_nxt;

  frm_restart_ctl #(.HOLD_EDGES(HOLD_EDGES)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .halt_i     (halt_i),
    .active_nxt (active_nxt),
    .running_q  (running_q)
  );

  frm_pos_ctr #(.ROWS(ROWS), .COLS(COLS)) u_pos (
    .clk        (clk),
    .active_nxt (active_nxt),
    .running_q  (running_q),
    .row_q      (row_o),
    .col_q      (col_o),
    .origin_nxt (origin_nxt)
  );

  frm_out_stage #(.DW(DW)) u_out (
    .clk        (clk),
    .rst        (rst),
    .active_nxt (active_nxt),
    .origin_nxt (origin_nxt),
    .byte_i     (tx_byte_i),
    .byte_q     (tx_byte_o),
    .pulse_q    (frame_pulse_o)
  );

  assign tx_valid_o = running_q;
endmodule

// File: rtl/sts3c_frame_timer_chk.sv
module sts3c_frame_timer_chk #(
  parameter int unsigned DW         = frm_pkg::DEF_DW,
  parameter int unsigned ROWS       = frm_pkg::DEF_ROWS,
  parameter int unsigned COLS       = frm_pkg::DEF_COLS,
  parameter int unsigned HOLD_EDGES = frm_pkg::DEF_HOLD
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         halt_i,
  input logic [DW-1:0]                tx_byte_o,
  input logic                         tx_valid_o,
  input logic                         frame_pulse_o,
  input logic [frm_pkg::cw(ROWS)-1:0] row_o,
  input logic [frm_pkg::cw(COLS)-1:0] col_o
);
  localparam int unsigned QW = frm_pkg::cw(HOLD_EDGES + 1);
  localparam logic [QW-1:0] QMAX = QW'(HOLD_EDGES);

  // Edges since the last edge that saw reset or halt high, saturating.
  logic [QW-1:0] quiet_q;
  always_ff @(posedge clk) begin
    if (rst || halt_i) quiet_q <= '0;
    else if (quiet_q != QMAX) quiet_q <= quiet_q + 1'b1;
  end

  p_pulse_origin_r4: assert property (@(posedge clk) disable iff (rst)
    frame_pulse_o |-> (tx_valid_o && row_o == '0 && col_o == '0));

  p_halt_idle_r5: assert property (@(posedge clk) disable iff (rst)
    halt_i |=> (!tx_valid_o && !frame_pulse_o && tx_byte_o == '0 && row_o == '0 && col_o == '0));

  p_no_early_start_r6: assert property (@(posedge clk) disable iff (rst)
    tx_valid_o |-> (quiet_q == QMAX));

  p_start_on_time_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid_o) |-> (frame_pulse_o && row_o == '0 && col_o == '0 && quiet_q == QMAX));

  p_col_step_r2: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_o && $past(tx_valid_o) && col_o != '0) |->
      (col_o == $past(col_o) + 1'b1 && row_o == $past(row_o)));

  p_frame_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_o && $past(tx_valid_o) && row_o == '0 && col_o == '0) |->
      ($past(row_o) == (ROWS - 1) && $past(col_o) == (COLS - 1)));

  p_idle_data_r8: assert property (@(posedge clk) disable iff (rst)
    !tx_valid_o |-> (tx_byte_o == '0 && !frame_pulse_o));
endmodule

bind sts3c_frame_timer sts3c_frame_timer_chk #(
  .DW(DW), .ROWS(ROWS), .COLS(COLS), .HOLD_EDGES(HOLD_EDGES)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .halt_i        (halt_i),
  .tx_byte_o     (tx_byte_o),
  .tx_valid_o    (tx_valid_o),
  .frame_pulse_o (frame_pulse_o),
  .row_o         (row_o),
  .col_o         (col_o)
);

// File: tb/sts3c_frame_timer_bench.sv
`timescale 1ns/1ps
module sts3c_frame_timer_bench;
  localparam int ROWS = 9;
  localparam int COLS = 270;
  localparam int FRAME = ROWS * COLS;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       halt = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       valid, pulse;
  logic [3:0] row;
  logic [8:0] col;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sts3c_frame_timer u_sts3c_frame_timer (
    .clk(clk), .rst(rst), .halt_i(halt), .tx_byte_i(din),
    .tx_byte_o(dout), .tx_valid_o(valid), .frame_pulse_o(pulse),
    .row_o(row), .col_o(col)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(!valid && !pulse && dout == 0 && row == 0 && col == 0, req,
          "idle outputs (valid,pulse,byte,row,col packed)",
          {valid, pulse, dout, row, col}, 0);
  endtask

  task automatic check_start(input string req);
    check(valid && pulse && row == 0 && col == 0, req,
          "frame start (valid,pulse,row,col packed)",
          {valid, pulse, row, col}, {1'b1, 1'b1, 4'd0, 9'd0});
  endtask

  // Called right after the last high-halt edge has been sampled.
  task automatic expect_restart(input string req);
    for (int i = 1; i <= 8; i++) begin
      step();
      check(!valid && !pulse, req, "still idle during countdown", {valid, pulse}, 0);
    end
    step();
    check_start(req);
  endtask

  task automatic t_reset();
    rst = 1'b1; halt = 1'b0; din = 8'h3C;
    step(); step();
    check_idle("R1");
    rst = 1'b0;
    expect_restart("R1");
    check(dout == 8'h3C, "R8", "first byte passed", dout, 8'h3C);
  endtask

  // Starts at a frame start; runs one full frame and checks the next start.
  task automatic t_full_frame();
    for (int i = 1; i < FRAME; i++) begin
      din = 8'(i * 7);
      step();
      check(valid && !pulse && row == i / COLS && col == i % COLS && dout == 8'(i * 7),
            (i % COLS == 0) ? "R2" : "R8", "position/byte mid-frame",
            {row, col}, {4'(i / COLS), 9'(i % COLS)});
    end
    step();
    check_start("R3");
    check(!(valid === 1'bx), "R4", "valid defined", valid, 1);
    step();
    check(!pulse && col == 1, "R4", "pulse one clock wide", pulse, 0);
  endtask

  task automatic t_halt_mid();
    for (int i = 0; i < 40; i++) step();
    halt = 1'b1; din = 8'hFF;
    step();
    check_idle("R5");
    halt = 1'b0;
    expect_restart("R6");
    check(dout == 8'hFF, "R8", "byte after restart", dout, 8'hFF);
  endtask

  task automatic t_long_halt();
    halt = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step();
      check_idle("R5");
    end
    halt = 1'b0;
    expect_restart("R6");
  endtask

  task automatic t_retrigger();
    halt = 1'b1; step(); halt = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      check(!valid, "R7", "idle before retrigger", valid, 0);
    end
    halt = 1'b1; step(); halt = 1'b0;
    check_idle("R7");
    expect_restart("R7");
  endtask

  task automatic t_retrigger_ninth();
    halt = 1'b1; step(); halt = 1'b0;
    for (int i = 0; i < 8; i++) step();
    halt = 1'b1; step(); halt = 1'b0;  // would have been edge nine
    check_idle("R7");
    expect_restart("R7");
  endtask

  task automatic t_halt_at_wrap();
    for (int i = 1; i < FRAME; i++) step();
    check(valid && row == ROWS - 1 && col == COLS - 1, "R3", "last byte of frame",
          {row, col}, {4'(ROWS - 1), 9'(COLS - 1)});
    halt = 1'b1; din = 8'h5A;
    step();
    check_idle("R5");
    halt = 1'b0;
    expect_restart("R5");
  endtask

  initial begin
    t_reset();
    t_full_frame();
    t_halt_mid();
    t_long_halt();
    t_retrigger();
    t_retrigger_ninth();
    t_halt_at_wrap();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule